// File: doc/BRIEF.md
# Dual Down-Counting Timer with Identification Window

This block holds two independent down-counting timer channels behind one 4 KB register window on a simple strobe bus. The lowest 32 bytes of the window address channel 0, and the next 32 bytes address channel 1. Each channel has its own count-enable input, so the two can run from different tick rates. A tick rate of 1 MHz is typical for both. Each channel has a prescaler, a 16- or 32-bit counter and three counting modes: periodic, free-running and one-shot. Each channel also keeps a sticky expiry flag that software can mask and clear.

The masked flags of both channels drive a single interrupt line. The top 32 bytes of the window return a fixed eight-entry identification table, one byte per word. The integration-test offsets and every other unused offset read as zero. Writes that fall outside the two channel slots have no effect. Read data is registered, so it appears on the cycle after the read strobe.

Top module: `dual_timer`

## Requirements
- R1: After synchronous reset each channel holds these values: control 0x20 (interrupt enable only), load 0, counter all ones, flag clear. The interrupt is low and the read data is 0.
- R2: Byte offsets 0x00–0x1F address channel 0 and 0x20–0x3F address channel 1. Within a slot the offsets are: 0x00 load (write also loads the counter), 0x04 current value (read only), 0x08 control, 0x0C flag clear (write only), 0x10 raw flag in bit 0, 0x14 masked flag in bit 0, 0x18 background load. Other slot offsets, and reads of 0x0C, return 0.
- R3: The control byte has these fields: bit 7 enable, bit 6 periodic, bit 5 interrupt enable, bits 3:2 prescale (01 = /16, 10 = /256, 00 or 11 = /1), bit 1 32-bit width, bit 0 one-shot.
- R4: While enabled, each prescaled tick decrements the counter by one. A decrement that reaches zero sets the raw flag.
- R5: A prescaled tick at zero acts by mode. One-shot holds zero and takes precedence. Periodic reloads the counter from the load register. Free-running (bits 6 and 0 both clear) wraps the counter to all ones of the current width.
- R6: At /16 the counter moves once per 16 ticks, and at /256 once per 256 ticks. A control write or a load write restarts the prescaler.
- R7: A background-load write changes the load register but not the counter. The new value is used at the next reload.
- R8: With the width bit clear, the counter value, its decrements and its loads use only the low 16 bits.
- R9: A flag-clear write clears the raw flag, but an expiry in the same cycle wins. The masked flag is the raw flag ANDed with interrupt enable. The interrupt output is the OR of both channels' masked flags.
- R10: Offsets 0xFE0–0xFFC are read only and return, by word index, 0x04, 0x18, 0x14, 0x00, 0x0D, 0xF0, 0x05, 0xB1.
- R11: These reads return 0: the test offsets 0xF00 and 0xF04, and every other offset outside the channel slots and the identification range. Writes outside the channel slots, and writes to the value register, change nothing.
- R12: Read data appears the cycle after a read strobe and holds until the next read. Each channel counts only on its own count-enable input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Single-cycle access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address within the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| tick_en | input | 2 | Per-channel count enable, bit i for channel i |
| irq | output | 1 | Merged interrupt |

## Verification
A corrupted counter or prescaler state shows up in the value register, and a read returns it on the next cycle. A wrong reload or wrap choice appears on the single tick after zero. A wrong flag or wrong mask shows on the interrupt pin in the same cycle as the expiry edge, with no extra latency. A decode fault shows up in a sweep of every word of the window, which compares each word against the identification table or against zero.

// File: rtl/dtmr_pkg.sv
package dtmr_pkg;

    localparam int ADDR_W    = 12;
    localparam int DATA_W    = 32;
    localparam int SLOT_AW   = 5;
    localparam int NUM_CH    = 2;
    localparam int PRE_W     = 8;
    localparam int NARROW_W  = 16;

    localparam logic [ADDR_W-1:0] TEST_CTRL_OFF = 12'hF00;
    localparam logic [ADDR_W-1:0] TEST_OUT_OFF  = 12'hF04;
    localparam logic [ADDR_W-SLOT_AW-1:0] ID_SLOT = '1;

    typedef enum logic [2:0] {
        REG_LOAD   = 3'd0,
        REG_VALUE  = 3'd1,
        REG_CTRL   = 3'd2,
        REG_ICLR   = 3'd3,
        REG_RAW    = 3'd4,
        REG_MSK    = 3'd5,
        REG_BGLOAD = 3'd6,
        REG_NONE   = 3'd7
    } reg_sel_e;

    typedef enum logic [1:0] {
        PS_DIV1   = 2'd0,
        PS_DIV16  = 2'd1,
        PS_DIV256 = 2'd2,
        PS_DIV1B  = 2'd3
    } presc_e;

    typedef struct packed {
        logic   en;
        logic   periodic;
        logic   ie;
        logic   spare;
        presc_e presc;
        logic   wide;
        logic   oneshot;
    } ctrl_t;

    localparam ctrl_t CTRL_RESET = '{en: 1'b0, periodic: 1'b0, ie: 1'b1,
                                     spare: 1'b0, presc: PS_DIV1,
                                     wide: 1'b0, oneshot: 1'b0};

    typedef enum logic [2:0] {
        NXT_KEEP,
        NXT_LOAD,
        NXT_DEC,
        NXT_RELOAD,
        NXT_WRAP
    } cnt_op_e;

    typedef struct packed {
        logic              wr;
        reg_sel_e          sel;
        logic [DATA_W-1:0] wdata;
    } chan_req_t;

    function automatic logic [7:0] id_byte(input logic [2:0] idx);
        logic [7:0] b;
        case (idx)
            3'd0:    b = 8'h04;
            3'd1:    b = 8'h18;
            3'd2:    b = 8'h14;
            3'd3:    b = 8'h00;
            3'd4:    b = 8'h0D;
            3'd5:    b = 8'hF0;
            3'd6:    b = 8'h05;
            default: b = 8'hB1;
        endcase
        return b;
    endfunction

    function automatic logic [DATA_W-1:0] width_mask(input logic wide);
        return wide ? {DATA_W{1'b1}} : {{(DATA_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};
    endfunction

endpackage

// File: rtl/dtmr_prescale.sv
module dtmr_prescale
    import dtmr_pkg::*;
#(
    parameter int W = PRE_W
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   clr,
    input  logic   tick,
    input  presc_e mode,
    output logic   step
);
    localparam int SHORT_W = (W < 4) ? W : 4;

    logic [W-1:0] pcnt;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            pcnt <= '0;
        end else if (tick) begin
            pcnt <= pcnt + 1'b1;
        end
    end

    always_comb begin
        case (mode)
            PS_DIV16:  step = tick && (&pcnt[SHORT_W-1:0]);
            PS_DIV256: step = tick && (&pcnt);
            default:   step = tick;
        endcase
    end

    // R6: at /16 and /256 a step comes only on the last tick of a cycle
    a_r6_div16_phase: assert property (@(posedge clk) disable iff (rst)
        (step && mode == PS_DIV16) |-> (pcnt[SHORT_W-1:0] == {SHORT_W{1'b1}}));

endmodule

// File: rtl/dtmr_counter.sv
module dtmr_counter
    import dtmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load_now,
    input  logic [DATA_W-1:0] load_val,
    input  logic [DATA_W-1:0] limit,
    input  logic              step,
    input  ctrl_t             ctrl,
    output logic [DATA_W-1:0] value,
    output logic              expire
);
    logic [DATA_W-1:0] cnt;
    logic [DATA_W-1:0] mask;
    logic [DATA_W-1:0] cur;
    logic              at_zero;
    cnt_op_e           op;

    assign mask    = width_mask(ctrl.wide);
    assign cur     = cnt & mask;
    assign at_zero = (cur == '0);

    always_comb begin
        if (load_now) begin
            op = NXT_LOAD;
        end else if (!step) begin
            op = NXT_KEEP;
        end else if (!at_zero) begin
            op = NXT_DEC;
        end else if (ctrl.oneshot) begin
            op = NXT_KEEP;
        end else if (ctrl.periodic) begin
            op = NXT_RELOAD;
        end else begin
            op = NXT_WRAP;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '1;
        end else begin
            case (op)
                NXT_LOAD:   cnt <= load_val & mask;
                NXT_DEC:    cnt <= (cur - 1'b1) & mask;
                NXT_RELOAD: cnt <= limit & mask;
                NXT_WRAP:   cnt <= mask;
                default:    cnt <= cnt;
            endcase
        end
    end

    assign value  = cur;
    assign expire = (op == NXT_DEC) && (cur == {{(DATA_W-1){1'b0}}, 1'b1});

    // R4: a step away from zero lowers the count by exactly one
    a_r4_decrement: assert property (@(posedge clk) disable iff (rst)
        (step && !load_now && !at_zero) |=> (cnt == (($past(cur) - 1'b1) & $past(mask))));

    // R5: one-shot holds the counter at zero
    a_r5_oneshot_hold: assert property (@(posedge clk) disable iff (rst)
        (step && !load_now && at_zero && ctrl.oneshot) |=> (cnt == $past(cnt)));

    // R5: free-running wraps to all ones of the width
    a_r5_freerun_wrap: assert property (@(posedge clk) disable iff (rst)
        (step && !load_now && at_zero && !ctrl.oneshot && !ctrl.periodic)
        |=> (cnt == $past(mask)));

endmodule

// File: rtl/dtmr_channel.sv
module dtmr_channel
    import dtmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_en,
    input  chan_req_t         req,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq
);
    ctrl_t             ctrl;
    logic [DATA_W-1:0] limit;
    logic              flag;
    logic              step;
    logic              expire;
    logic [DATA_W-1:0] value;
    logic              wr_load;
    logic              wr_ctrl;
    logic              wr_clr;
    logic              wr_bg;

    assign wr_load = req.wr && (req.sel == REG_LOAD);
    assign wr_ctrl = req.wr && (req.sel == REG_CTRL);
    assign wr_clr  = req.wr && (req.sel == REG_ICLR);
    assign wr_bg   = req.wr && (req.sel == REG_BGLOAD);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl  <= CTRL_RESET;
            limit <= '0;
        end else begin
            if (wr_ctrl) begin
                ctrl <= ctrl_t'(req.wdata[7:0]);
            end
            if (wr_load || wr_bg) begin
                limit <= req.wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flag <= 1'b0;
        end else if (expire) begin
            flag <= 1'b1;
        end else if (wr_clr) begin
            flag <= 1'b0;
        end
    end

    dtmr_prescale #(.W(PRE_W)) u_pre (
        .clk  (clk),
        .rst  (rst),
        .clr  (wr_ctrl || wr_load),
        .tick (tick_en && ctrl.en),
        .mode (ctrl.presc),
        .step (step)
    );

    dtmr_counter u_cnt (
        .clk      (clk),
        .rst      (rst),
        .load_now (wr_load),
        .load_val (req.wdata),
        .limit    (limit),
        .step     (step),
        .ctrl     (ctrl),
        .value    (value),
        .expire   (expire)
    );

    always_comb begin
        case (req.sel)
            REG_LOAD, REG_BGLOAD: rd_data = limit;
            REG_VALUE:            rd_data = value;
            REG_CTRL:             rd_data = {{(DATA_W-8){1'b0}}, ctrl};
            REG_RAW:              rd_data = {{(DATA_W-1){1'b0}}, flag};
            REG_MSK:              rd_data = {{(DATA_W-1){1'b0}}, flag && ctrl.ie};
            default:              rd_data = '0;
        endcase
    end

    assign irq = flag && ctrl.ie;

    // R9: a clear without a same-cycle expiry empties the flag
    a_r9_clear: assert property (@(posedge clk) disable iff (rst)
        (wr_clr && !expire) |=> !flag);

    // R9: the flag is sticky until cleared
    a_r9_sticky: assert property (@(posedge clk) disable iff (rst)
        (flag && !wr_clr) |=> flag);

    // R9: an expiry always leaves the flag set
    a_r9_expiry_wins: assert property (@(posedge clk) disable iff (rst)
        expire |=> flag);

endmodule

// File: rtl/dual_timer.sv
module dual_timer
    import dtmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NUM_CH-1:0] tick_en,
    output logic              irq
);
    localparam int SLOT_IDX_W = ADDR_W - SLOT_AW;

    logic [SLOT_IDX_W-1:0] slot;
    reg_sel_e              word_sel;
    logic                  rd_now;
    logic [NUM_CH-1:0]     in_slot;
    logic [NUM_CH-1:0]     ch_irq;
    logic [DATA_W-1:0]     ch_rd [NUM_CH];
    logic [DATA_W-1:0]     rd_mux;

    assign slot     = bus_addr[ADDR_W-1:SLOT_AW];
    assign word_sel = reg_sel_e'(bus_addr[SLOT_AW-1:2]);
    assign rd_now   = bus_sel && !bus_we;

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        chan_req_t req;
        assign in_slot[i] = (slot == SLOT_IDX_W'(i));
        assign req.wr     = bus_sel && bus_we && in_slot[i];
        assign req.sel    = word_sel;
        assign req.wdata  = bus_wdata;

        dtmr_channel u_chan (
            .clk     (clk),
            .rst     (rst),
            .tick_en (tick_en[i]),
            .req     (req),
            .rd_data (ch_rd[i]),
            .irq     (ch_irq[i])
        );
    end

    always_comb begin
        rd_mux = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (in_slot[i]) begin
                rd_mux = ch_rd[i];
            end
        end
        if (slot == ID_SLOT) begin
            rd_mux = {{(DATA_W-8){1'b0}}, id_byte(bus_addr[SLOT_AW-1:2])};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata <= '0;
        end else if (rd_now) begin
            bus_rdata <= rd_mux;
        end
    end

    assign irq = |ch_irq;

    // R11: the test offsets read back as zero
    a_r11_test_regs_zero: assert property (@(posedge clk) disable iff (rst)
        (rd_now && (bus_addr == TEST_CTRL_OFF || bus_addr == TEST_OUT_OFF))
        |=> (bus_rdata == '0));

    // R10: identification words carry one byte only
    a_r10_id_byte_only: assert property (@(posedge clk) disable iff (rst)
        (rd_now && slot == ID_SLOT) |=> (bus_rdata[DATA_W-1:8] == '0));

    // R12: read data holds while no read is strobed
    a_r12_rdata_hold: assert property (@(posedge clk) disable iff (rst)
        !rd_now |=> $stable(bus_rdata));

    // R9: the merged line is low while no channel requests
    a_r9_irq_quiet: assert property (@(posedge clk) disable iff (rst)
        (ch_irq == '0) |-> !irq);

endmodule

// File: tb/dual_timer_tb.sv
module dual_timer_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [1:0]  tick_en = '0;
    logic        irq;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    dual_timer u_dut (
        .clk       (clk),
        .rst       (rst),
        .bus_sel   (bus_sel),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .tick_en   (tick_en),
        .irq       (irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
        d = bus_rdata;
    endtask

    task automatic rchk(input string req, input logic [11:0] a, input logic [31:0] exp);
        logic [31:0] d;
        rd(a, d);
        chk(req, d, exp);
    endtask

    task automatic tick(input logic [1:0] m, input int n);
        if (n > 0) begin
            @(negedge clk);
            tick_en = m;
            repeat (n) @(negedge clk);
            tick_en = '0;
        end
    endtask

    function automatic logic [7:0] exp_id(input int k);
        logic [7:0] t [8] = '{8'h04, 8'h18, 8'h14, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
        return t[k];
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk("R1 rdata", bus_rdata, 32'h0);
        chk("R1 irq", {31'b0, irq}, 32'h0);
        rchk("R1 ctrl0", 12'h008, 32'h20);
        rchk("R1 ctrl1", 12'h028, 32'h20);
        rchk("R1 value0", 12'h004, 32'h0000FFFF);
        rchk("R1 value1", 12'h024, 32'h0000FFFF);
        rchk("R1 load0", 12'h000, 32'h0);
        rchk("R1 raw1", 12'h030, 32'h0);

        // R10 R11 sweep of every word outside the channel slots
        for (int a = 12'h040; a <= 12'hFFC; a += 4) begin
            logic [31:0] e;
            e = (a >= 12'hFE0) ? {24'h0, exp_id((a - 12'hFE0) / 4)} : 32'h0;
            rchk(a >= 12'hFE0 ? "R10 id" : "R11 unmapped", a[11:0], e);
        end

        // R12 hold after an identification read
        rchk("R12 id read", 12'hFE4, 32'h18);
        repeat (3) @(negedge clk);
        chk("R12 hold", bus_rdata, 32'h18);

        // R2 R4 R5 periodic 32-bit on channel 0
        wr(12'h008, 32'h62);
        wr(12'h000, 32'd5);
        rchk("R2 load reloads count", 12'h004, 32'd5);
        wr(12'h008, 32'hE2);
        tick(2'b01, 4);
        rchk("R4 dec", 12'h004, 32'd1);
        chk("R4 no irq yet", {31'b0, irq}, 32'h0);
        tick(2'b01, 1);
        chk("R4 irq at zero", {31'b0, irq}, 32'h1);
        rchk("R2 raw", 12'h010, 32'h1);
        rchk("R2 masked", 12'h014, 32'h1);
        rchk("R2 clear reads 0", 12'h00C, 32'h0);
        tick(2'b01, 1);
        rchk("R5 periodic reload", 12'h004, 32'd5);
        wr(12'h00C, 32'h0);
        chk("R9 clear", {31'b0, irq}, 32'h0);
        for (int l = 1; l <= 8; l++) begin
            wr(12'h000, l);
            tick(2'b01, l - 1);
            rchk("R4 sweep before", 12'h010, 32'h0);
            tick(2'b01, 1);
            rchk("R4 sweep value", 12'h004, 32'h0);
            rchk("R4 sweep raw", 12'h010, 32'h1);
            wr(12'h00C, 32'h0);
        end

        // R3 R9 interrupt enable masking
        wr(12'h008, 32'hC2);
        wr(12'h000, 32'd2);
        tick(2'b01, 2);
        rchk("R9 raw masked off", 12'h010, 32'h1);
        rchk("R9 masked zero", 12'h014, 32'h0);
        chk("R9 irq masked", {31'b0, irq}, 32'h0);
        wr(12'h008, 32'hE2);
        chk("R3 ie on irq", {31'b0, irq}, 32'h1);
        wr(12'h00C, 32'h0);

        // R12 independence, R9 OR merge
        wr(12'h028, 32'hE2);
        wr(12'h020, 32'd3);
        tick(2'b10, 3);
        rchk("R12 ch1 counted", 12'h024, 32'h0);
        rchk("R12 ch0 untouched", 12'h004, 32'h0);
        rchk("R12 ch0 flag", 12'h010, 32'h0);
        chk("R9 irq from ch1", {31'b0, irq}, 32'h1);
        wr(12'h000, 32'd1);
        tick(2'b01, 1);
        wr(12'h02C, 32'h0);
        chk("R9 irq from ch0", {31'b0, irq}, 32'h1);
        wr(12'h00C, 32'h0);
        chk("R9 irq both clear", {31'b0, irq}, 32'h0);

        // R6 prescaler
        wr(12'h008, 32'hE6);
        wr(12'h000, 32'd10);
        tick(2'b01, 15);
        rchk("R6 div16 hold", 12'h004, 32'd10);
        tick(2'b01, 1);
        rchk("R6 div16 step", 12'h004, 32'd9);
        tick(2'b01, 32);
        rchk("R6 div16 two", 12'h004, 32'd7);
        wr(12'h008, 32'hEA);
        wr(12'h000, 32'd10);
        tick(2'b01, 255);
        rchk("R6 div256 hold", 12'h004, 32'd10);
        tick(2'b01, 1);
        rchk("R6 div256 step", 12'h004, 32'd9);
        wr(12'h008, 32'hEE);
        tick(2'b01, 3);
        rchk("R3 presc 11 is div1", 12'h004, 32'd6);

        // R5 one-shot
        wr(12'h008, 32'hE3);
        wr(12'h000, 32'd2);
        tick(2'b01, 2);
        rchk("R5 oneshot zero", 12'h004, 32'h0);
        wr(12'h00C, 32'h0);
        tick(2'b01, 3);
        rchk("R5 oneshot hold", 12'h004, 32'h0);
        rchk("R5 oneshot no refire", 12'h010, 32'h0);

        // R5 R8 free-running narrow and wide
        wr(12'h008, 32'hA0);
        wr(12'h000, 32'd2);
        tick(2'b01, 2);
        rchk("R5 freerun zero", 12'h004, 32'h0);
        tick(2'b01, 1);
        rchk("R8 wrap 16", 12'h004, 32'h0000FFFF);
        wr(12'h00C, 32'h0);
        wr(12'h000, 32'h00012345);
        rchk("R8 narrow load", 12'h004, 32'h2345);
        rchk("R8 load reg full", 12'h000, 32'h00012345);
        tick(2'b01, 1);
        rchk("R8 narrow dec", 12'h004, 32'h2344);
        wr(12'h008, 32'hA2);
        wr(12'h000, 32'd1);
        tick(2'b01, 2);
        rchk("R5 wrap 32", 12'h004, 32'hFFFFFFFF);
        wr(12'h00C, 32'h0);

        // R7 background load
        wr(12'h008, 32'hE2);
        wr(12'h000, 32'd4);
        wr(12'h018, 32'd9);
        rchk("R7 count kept", 12'h004, 32'd4);
        rchk("R7 load reg", 12'h000, 32'd9);
        rchk("R7 bg readback", 12'h018, 32'd9);
        tick(2'b01, 4);
        tick(2'b01, 1);
        rchk("R7 next reload", 12'h004, 32'd9);
        wr(12'h00C, 32'h0);

        // R11 ignored writes
        wr(12'h004, 32'h77);
        rchk("R11 value write ignored", 12'h004, 32'd9);
        wr(12'hFE4, 32'hFF);
        rchk("R11 id write ignored", 12'hFE4, 32'h18);
        wr(12'hF00, 32'hFF);
        wr(12'h040, 32'h0);
        wr(12'h800, 32'h0);
        rchk("R11 ch0 ctrl kept", 12'h008, 32'hE2);
        rchk("R11 ch1 ctrl kept", 12'h028, 32'hE2);
        rchk("R2 hole 1C", 12'h01C, 32'h0);
        rchk("R2 hole 3C", 12'h03C, 32'h0);
        rd(12'h02C, d);
        chk("R2 ch1 clear reads 0", d, 32'h0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule